// File: doc/BRIEF.md
# Load/Store Queue with Speculative Squash

This block keeps one thread's load and store micro-ops in two program-ordered queues and hands them to a data-memory port. Stores leave strictly from the head of their queue, and only once the retirement logic has marked them committed. Loads are scanned from oldest to youngest. Any load whose operands are ready issues, and loads that are not ready are skipped over. Both queues share one per-cycle issue budget, and stores are served before loads.

A single recovery pulse throws away every entry tagged speculative, in both queues at once. The surviving entries close up and keep their order. Each issued entry leaves its queue at the next clock edge and appears on one of the request slots with its address and its kind. Commit marks and operand-ready marks arrive as tag broadcasts. A mark is latched in the matching entry, so it counts from the next cycle on and never has to be presented again.

Top module: `lsq_squash`

## Requirements
- R1: After reset both queues are empty, no request slot is valid and `enq_ack` is low while `enq_valid` is low.
- R2: An enqueue aimed at a full queue (DEPTH entries) is refused: `enq_ack` stays low and the entry is dropped. The other queue still accepts entries.
- R3: A store is eligible only once it is committed. It is committed either because `enq_done` was set when it was enqueued, or because `commit_valid` was pulsed with its tag. Either way, eligibility starts in the cycle after the mark.
- R4: Stores drain in program order. Draining stops at the oldest store that is not committed, even when younger stores behind it are committed.
- R5: While `mem_ready` is low, no request of either kind is issued.
- R6: A load is eligible once its operands are ready. Eligible loads issue oldest first, and a load that is not ready is skipped so that younger ready loads can still issue.
- R7: A load's readiness comes from `enq_done` at enqueue or from an `opnd_valid` pulse carrying its tag. It is latched, so a pulse that arrives while the port is busy still takes effect later.
- R8: At most BUDGET requests are issued per cycle. Stores take slots before loads, and the slots fill from index 0 upward in issue order.
- R9: A `squash` pulse removes every speculative entry from both queues. The non-speculative entries keep their relative order.
- R10: In a cycle with `squash` high, no request is issued.
- R11: An issued entry leaves its queue. Its request carries its address on `req_addr` and its kind on `req_store` (1 = store, 0 = load). Each entry issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_store | input | 1 | 1 = store entry, 0 = load entry |
| enq_addr | input | AW | Memory address of the entry |
| enq_tag | input | TW | Tag used by commit and operand-ready marks |
| enq_spec | input | 1 | Entry is speculative |
| enq_done | input | 1 | Store already committed / load operands already ready |
| enq_ack | output | 1 | Enqueue accepted this cycle |
| commit_valid | input | 1 | Commit mark for stores |
| commit_tag | input | TW | Tag of the committed store |
| opnd_valid | input | 1 | Operand-ready mark for loads |
| opnd_tag | input | TW | Tag of the load whose operands became ready |
| mem_ready | input | 1 | Memory port can accept requests |
| squash | input | 1 | Recovery pulse: drop all speculative entries |
| req_valid | output | BUDGET | Per-slot request valid |
| req_store | output | BUDGET | Per-slot kind, 1 = store |
| req_addr | output | BUDGET*AW | Per-slot address, slot k in bits [k*AW +: AW] |

## Verification
Stores are driven in three patterns, each separating one cause of stall from the others. In the first, an uncommitted store sits ahead of committed ones, which shows ordered draining apart from mere eligibility. In the second, a row of committed stores waits behind a busy port, which exercises the budget split. In the third, stores are mixed with ready loads, which exercises store-first slot ordering. Loads are made ready out of program order and during busy cycles, which shows skipping apart from blocking and latched readiness apart from a level-sensitive one. A squash is applied to interleaved speculative and non-speculative entries in both queues, and again after a refused enqueue into a full queue. This shows whether the survivors keep their order and whether the dropped entry ever reappears.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {KIND_LOAD = 1'b0, KIND_STORE = 1'b1} kind_e;

  // Bits needed to hold a count from 0 to n.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Bits needed to index n slots (at least one).
  function automatic int idx_bits(input int n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lsq_queue.sv
module lsq_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_req,
  input  logic [AW-1:0]       enq_addr,
  input  logic [TW-1:0]       enq_tag,
  input  logic                enq_spec,
  input  logic                enq_done,
  output logic                enq_ack,
  input  logic                mark_valid,
  input  logic [TW-1:0]       mark_tag,
  input  logic [DEPTH-1:0]    issue_mask,
  input  logic                squash,
  output logic [DEPTH-1:0]    slot_vld,
  output logic [DEPTH-1:0]    slot_done,
  output logic [DEPTH*AW-1:0] slot_addr
);
  localparam int CW = lsq_pkg::cnt_bits(DEPTH);
  localparam int IW = lsq_pkg::idx_bits(DEPTH);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [TW-1:0]    tag_q  [DEPTH];
  logic [DEPTH-1:0] spec_q, done_q;
  logic [CW-1:0]    cnt_q;

  logic [AW-1:0]    addr_d [DEPTH];
  logic [TW-1:0]    tag_d  [DEPTH];
  logic [DEPTH-1:0] spec_d, done_d;
  logic [CW-1:0]    cnt_d;

  // Named internal events for the assertions.
  logic [DEPTH-1:0] keep, done_upd;
  logic             q_full;

  assign q_full  = (cnt_q == CW'(DEPTH));
  assign enq_ack = enq_req && !q_full;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_vld[i] = (CW'(i) < cnt_q);
      done_upd[i] = done_q[i] | (mark_valid && tag_q[i] == mark_tag);
      keep[i]     = slot_vld[i] && (squash ? !spec_q[i] : !issue_mask[i]);
    end
  end

  // Close the gaps left by issued or squashed entries, then append.
  always_comb begin
    logic [IW-1:0] wp;
    logic [CW-1:0] kept;
    addr_d = addr_q;
    tag_d  = tag_q;
    spec_d = '0;
    done_d = '0;
    wp     = '0;
    kept   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        addr_d[wp] = addr_q[i];
        tag_d[wp]  = tag_q[i];
        spec_d[wp] = spec_q[i];
        done_d[wp] = done_upd[i];
        wp   = wp + 1'b1;
        kept = kept + 1'b1;
      end
    end
    if (enq_ack) begin
      addr_d[wp] = enq_addr;
      tag_d[wp]  = enq_tag;
      spec_d[wp] = enq_spec;
      done_d[wp] = enq_done;
      kept = kept + 1'b1;
    end
    cnt_d = kept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      spec_q <= '0;
      done_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      cnt_q  <= cnt_d;
      spec_q <= spec_d;
      done_q <= done_d;
      addr_q <= addr_d;
      tag_q  <= tag_d;
    end
  end

  assign slot_done = done_q & slot_vld;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_pack
      assign slot_addr[g*AW +: AW] = addr_q[g];
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_req && q_full && issue_mask == '0 && !squash) |=> q_full); // R2
  AST_SQUASH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && !enq_req) |=> ((spec_q & slot_vld) == '0)); // R9
endmodule

// File: rtl/lsq_pick.sv
module lsq_pick #(
  parameter int DEPTH    = 8,
  parameter int BUDGET   = 2,
  parameter bit IN_ORDER = 1'b0,
  parameter int BW       = lsq_pkg::cnt_bits(BUDGET)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] elig,
  input  logic [BW-1:0]    budget,
  output logic [DEPTH-1:0] grant,
  output logic [BW-1:0]    used
);
  logic [BW-1:0] left_final;

  generate
    if (IN_ORDER) begin : g_ord
      // Head-first: the first ineligible entry ends the scan.
      always_comb begin
        logic [BW-1:0] left;
        logic          blocked;
        left    = budget;
        blocked = 1'b0;
        grant   = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (!blocked && left != '0) begin
            if (elig[i]) begin
              grant[i] = 1'b1;
              left     = left - 1'b1;
            end else begin
              blocked = 1'b1;
            end
          end
        end
        left_final = left;
      end
      for (genvar g = 1; g < DEPTH; g++) begin : g_chk
        AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
          grant[g] |-> grant[g-1]); // R4
      end
    end else begin : g_ooo
      // Oldest-first with skipping of ineligible entries.
      always_comb begin
        logic [BW-1:0] left;
        left  = budget;
        grant = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (left != '0 && elig[i]) begin
            grant[i] = 1'b1;
            left     = left - 1'b1;
          end
        end
        left_final = left;
      end
    end
  endgenerate

  assign used = budget - left_final;

  AST_GRANT_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= int'(budget)); // R8
  AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0); // R3
endmodule

// File: rtl/lsq_squash.sv
module lsq_squash #(
  parameter int DEPTH  = 8,
  parameter int AW     = 16,
  parameter int TW     = 4,
  parameter int BUDGET = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  input  logic                 enq_store,
  input  logic [AW-1:0]        enq_addr,
  input  logic [TW-1:0]        enq_tag,
  input  logic                 enq_spec,
  input  logic                 enq_done,
  output logic                 enq_ack,
  input  logic                 commit_valid,
  input  logic [TW-1:0]        commit_tag,
  input  logic                 opnd_valid,
  input  logic [TW-1:0]        opnd_tag,
  input  logic                 mem_ready,
  input  logic                 squash,
  output logic [BUDGET-1:0]    req_valid,
  output logic [BUDGET-1:0]    req_store,
  output logic [BUDGET*AW-1:0] req_addr
);
  import lsq_pkg::*;
  localparam int BW = cnt_bits(BUDGET);
  localparam int SW = idx_bits(BUDGET);

  logic             sq_ack, lq_ack;
  logic [DEPTH-1:0] sq_vld, sq_done, sq_elig, sq_grant;
  logic [DEPTH-1:0] lq_vld, lq_done, lq_elig, lq_grant;
  logic [DEPTH*AW-1:0] sq_addr, lq_addr;
  logic [BW-1:0]    st_budget, ld_budget, st_used, ld_used;
  logic [AW-1:0]    raddr [BUDGET];

  assign enq_ack = sq_ack | lq_ack;

  lsq_queue #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .enq_req(enq_valid && enq_store), .enq_addr(enq_addr), .enq_tag(enq_tag),
    .enq_spec(enq_spec), .enq_done(enq_done), .enq_ack(sq_ack),
    .mark_valid(commit_valid), .mark_tag(commit_tag),
    .issue_mask(sq_grant), .squash(squash),
    .slot_vld(sq_vld), .slot_done(sq_done), .slot_addr(sq_addr));

  lsq_queue #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .enq_req(enq_valid && !enq_store), .enq_addr(enq_addr), .enq_tag(enq_tag),
    .enq_spec(enq_spec), .enq_done(enq_done), .enq_ack(lq_ack),
    .mark_valid(opnd_valid), .mark_tag(opnd_tag),
    .issue_mask(lq_grant), .squash(squash),
    .slot_vld(lq_vld), .slot_done(lq_done), .slot_addr(lq_addr));

  assign sq_elig   = sq_done & {DEPTH{mem_ready}};
  assign lq_elig   = lq_done & {DEPTH{mem_ready}};
  assign st_budget = squash ? '0 : BW'(BUDGET);
  assign ld_budget = st_budget - st_used;

  lsq_pick #(.DEPTH(DEPTH), .BUDGET(BUDGET), .IN_ORDER(1'b1), .BW(BW)) u_st_pick (
    .clk(clk), .rst_n(rst_n), .elig(sq_elig), .budget(st_budget),
    .grant(sq_grant), .used(st_used));

  lsq_pick #(.DEPTH(DEPTH), .BUDGET(BUDGET), .IN_ORDER(1'b0), .BW(BW)) u_ld_pick (
    .clk(clk), .rst_n(rst_n), .elig(lq_elig), .budget(ld_budget),
    .grant(lq_grant), .used(ld_used));

  // Slot assembly: granted stores first, then granted loads, oldest first.
  always_comb begin
    logic [SW-1:0] k;
    k         = '0;
    req_valid = '0;
    req_store = '0;
    for (int j = 0; j < BUDGET; j++) raddr[j] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sq_grant[i]) begin
        req_valid[k] = 1'b1;
        req_store[k] = KIND_STORE;
        raddr[k]     = sq_addr[i*AW +: AW];
        k = k + 1'b1;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (lq_grant[i]) begin
        req_valid[k] = 1'b1;
        req_store[k] = KIND_LOAD;
        raddr[k]     = lq_addr[i*AW +: AW];
        k = k + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < BUDGET; g++) begin : g_req
      assign req_addr[g*AW +: AW] = raddr[g];
    end
  endgenerate

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (req_valid == '0)); // R10
  AST_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (req_valid == '0)); // R5
  AST_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(st_used) + int'(ld_used)) <= BUDGET); // R8
  AST_STORE_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_grant & ~sq_done) == '0); // R3
  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_grant & ~lq_done) == '0); // R6
  AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_valid) == (int'(st_used) + int'(ld_used))); // R8
endmodule

// File: tb/lsq_squash_test.sv
module lsq_squash_test;
  localparam int DEPTH  = 8;
  localparam int AW     = 16;
  localparam int TW     = 4;
  localparam int BUDGET = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 0, enq_store = 0, enq_spec = 0, enq_done = 0;
  logic [AW-1:0] enq_addr = '0;
  logic [TW-1:0] enq_tag = '0, commit_tag = '0, opnd_tag = '0;
  logic commit_valid = 0, opnd_valid = 0, mem_ready = 0, squash = 0;
  logic enq_ack;
  logic [BUDGET-1:0] req_valid, req_store;
  logic [BUDGET*AW-1:0] req_addr;

  int checks = 0;
  int errors = 0;
  int last_n = 0;
  bit finished = 0;
  logic [AW:0] exp_q [$];

  always #10 clk = ~clk;

  lsq_squash #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .BUDGET(BUDGET)) uut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_store(enq_store),
    .enq_addr(enq_addr), .enq_tag(enq_tag), .enq_spec(enq_spec), .enq_done(enq_done),
    .enq_ack(enq_ack), .commit_valid(commit_valid), .commit_tag(commit_tag),
    .opnd_valid(opnd_valid), .opnd_tag(opnd_tag), .mem_ready(mem_ready),
    .squash(squash), .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr));

  // Monitor: pops the scoreboard for every request, slot 0 first.
  always @(negedge clk) begin
    int n;
    n = 0;
    for (int s = 0; s < BUDGET; s++) begin
      if (req_valid[s]) begin
        logic [AW:0] got;
        n++;
        got = {req_store[s], req_addr[s*AW +: AW]};
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected request: actual kind=%0d addr=%h expected none",
                   got[AW], got[AW-1:0]);
        end else begin
          logic [AW:0] want;
          want = exp_q.pop_front();
          if (got !== want) begin
            errors++;
            $display("FAIL R11 request mismatch: actual kind=%0d addr=%h expected kind=%0d addr=%h",
                     got[AW], got[AW-1:0], want[AW], want[AW-1:0]);
          end
        end
      end
    end
    last_n = n;
  end

  task automatic expect_req(input logic st, input logic [AW-1:0] a);
    exp_q.push_back({st, a});
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Check the number of requests in the current cycle, then advance.
  task automatic step_chk(input int want, input string req);
    @(negedge clk); #1;
    checks++;
    if (last_n != want) begin
      errors++;
      $display("FAIL %s request count: actual %0d expected %0d", req, last_n, want);
    end
    @(posedge clk); #1;
  endtask

  task automatic enq(input logic st, input logic [AW-1:0] a, input logic [TW-1:0] t,
                     input logic sp, input logic dn, input logic want_ack, input string req);
    enq_valid = 1; enq_store = st; enq_addr = a; enq_tag = t; enq_spec = sp; enq_done = dn;
    #1;
    checks++;
    if (enq_ack !== want_ack) begin
      errors++;
      $display("FAIL %s enq_ack: actual %0b expected %0b", req, enq_ack, want_ack);
    end
    step();
    enq_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R1: empty after reset
    checks++;
    if (enq_ack !== 1'b0 || req_valid !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual ack=%0b req=%b expected 0/00", enq_ack, req_valid);
    end
    step_chk(0, "R1");

    // R3/R4: in-order drain blocked by an uncommitted store
    mem_ready = 1;
    expect_req(1, 16'h0100);
    enq(1, 16'h0100, 4'd1, 0, 1, 1, "R3");
    enq(1, 16'h0104, 4'd2, 0, 0, 1, "R3");
    enq(1, 16'h0108, 4'd3, 0, 1, 1, "R3");
    step_chk(0, "R4");
    step_chk(0, "R4");
    commit_valid = 1; commit_tag = 4'd2;
    step_chk(0, "R3");
    commit_valid = 0;
    expect_req(1, 16'h0104);
    expect_req(1, 16'h0108);
    step_chk(2, "R4");
    step_chk(0, "R4");

    // R5/R8: busy port then budget split
    mem_ready = 0;
    enq(1, 16'h0200, 4'd4, 0, 1, 1, "R8");
    enq(1, 16'h0204, 4'd5, 0, 1, 1, "R8");
    enq(1, 16'h0208, 4'd6, 0, 1, 1, "R8");
    step_chk(0, "R5");
    mem_ready = 1;
    expect_req(1, 16'h0200);
    expect_req(1, 16'h0204);
    expect_req(1, 16'h0208);
    step_chk(2, "R8");
    step_chk(1, "R8");
    step_chk(0, "R8");

    // R6/R7: out-of-order loads, latched readiness
    mem_ready = 0;
    enq(0, 16'h0300, 4'd8, 0, 0, 1, "R6");
    enq(0, 16'h0304, 4'd9, 0, 0, 1, "R6");
    enq(0, 16'h0308, 4'd10, 0, 0, 1, "R6");
    mem_ready = 1;
    step_chk(0, "R6");
    opnd_valid = 1; opnd_tag = 4'd10;
    step_chk(0, "R7");
    opnd_valid = 0;
    expect_req(0, 16'h0308);
    step_chk(1, "R6");
    mem_ready = 0;
    opnd_valid = 1; opnd_tag = 4'd9;
    step_chk(0, "R5");
    opnd_valid = 0;
    step_chk(0, "R5");
    mem_ready = 1;
    expect_req(0, 16'h0304);
    step_chk(1, "R7");
    opnd_valid = 1; opnd_tag = 4'd8;
    step_chk(0, "R7");
    opnd_valid = 0;
    expect_req(0, 16'h0300);
    step_chk(1, "R6");

    // R9/R10: squash both queues
    mem_ready = 0;
    enq(1, 16'h0400, 4'd11, 0, 1, 1, "R9");
    enq(1, 16'h0404, 4'd12, 1, 1, 1, "R9");
    enq(1, 16'h0408, 4'd13, 0, 1, 1, "R9");
    enq(0, 16'h040C, 4'd14, 1, 1, 1, "R9");
    enq(0, 16'h0410, 4'd15, 0, 1, 1, "R9");
    squash = 1; mem_ready = 1;
    step_chk(0, "R10");
    squash = 0;
    expect_req(1, 16'h0400);
    expect_req(1, 16'h0408);
    step_chk(2, "R9");
    expect_req(0, 16'h0410);
    step_chk(1, "R9");
    step_chk(0, "R9");

    // R8: stores take slots ahead of loads
    mem_ready = 0;
    enq(1, 16'h0500, 4'd1, 0, 1, 1, "R8");
    enq(0, 16'h0504, 4'd2, 0, 1, 1, "R8");
    enq(0, 16'h0508, 4'd3, 0, 1, 1, "R8");
    mem_ready = 1;
    expect_req(1, 16'h0500);
    expect_req(0, 16'h0504);
    step_chk(2, "R8");
    expect_req(0, 16'h0508);
    step_chk(1, "R8");

    // R2: full load queue refuses, store queue still accepts
    mem_ready = 0;
    for (int i = 0; i < DEPTH; i++)
      enq(0, 16'h0600 + 16'(4 * i), TW'(i), 1, 0, 1, "R2");
    enq(0, 16'h0700, 4'd9, 0, 1, 0, "R2");
    enq(1, 16'h0710, 4'd9, 0, 1, 1, "R2");
    squash = 1; mem_ready = 1;
    step_chk(0, "R10");
    squash = 0;
    expect_req(1, 16'h0710);
    step_chk(1, "R2");
    expect_req(0, 16'h0720);
    enq(0, 16'h0720, 4'd3, 0, 1, 1, "R2");
    step_chk(1, "R2");
    step_chk(0, "R2");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending requests: actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule